// File: doc/BRIEF.md
# DMA Control-Port Write Sequencer

This block sits behind the one byte-wide control port of a classic three-port-style DMA controller. Software programs the controller by writing a stream of bytes into that port. When nothing is pending, a byte is a base byte: its top bit and low bits pick a register group, the group register takes the byte, and the flag bits inside the byte name the parameter bytes that must follow. The block keeps those names in a small ring of pending targets. Each later byte goes to the oldest pending target, until the ring is empty again.

Command bytes (low two bits both set, top bit set) act at once. They copy programmed addresses into the working counters, restart a paused transfer, switch the enables, or latch a forced ready level. A separate transfer engine, which is not part of this block, reports progress through four single-cycle event inputs: a byte moved, a match was seen, the block ended, or the transfer paused part-way.

The write side is a valid/ready stream. `wr_ready` is held high, so every beat with `wr_valid` high is taken in the cycle it is offered and there is never back-pressure. All other pins are plain levels or pulses, and every result is visible on the cycle after the accepting clock edge.

Top module: `dma_cmd_seq`

## Requirements
- R1: Every accepted write clears `dma_en`. It becomes 1 again only through the enable command (code 0x87), the continue command (0xD3), or a group-3 base byte with bit 6 set.
- R2: A base byte with bit 7 = 0 and bits 1:0 ≠ 00 loads `xfer_kind` with bits 1:0. Its bits 3, 4, 5 and 6 queue, in this order, the low byte of `addr_a`, the high byte of `addr_a`, the low byte of `blk_len` and the high byte of `blk_len`. Clear bits are skipped.
- R3: A base byte with bit 7 = 0 and bits 1:0 = 00 goes to `cfg_a` when bit 2 = 1 and to `cfg_b` when bit 2 = 0. Its bit 6 queues one timing byte, which is consumed and changes nothing else.
- R4: A base byte with bit 7 = 1 and bits 1:0 = 00 sets `int_en` from bit 5 and `dma_en` from bit 6. Its bit 3 queues `mask_byte` and its bit 4 queues `match_byte`.
- R5: A base byte with bit 7 = 1 and bits 1:0 = 01 loads `xfer_mode` from bits 6:5. Its bits 2, 3 and 4 queue the low byte of `addr_b`, the high byte of `addr_b` and `ictl_byte`. When bits 6:5 = 11 the byte is dropped entirely.
- R6: When the interrupt-control byte is written, its bit 3 appends a `pulse_byte` target and then its bit 4 appends a `vec_byte` target at the tail of the pending ring.
- R7: A base byte with bit 7 = 1 and bits 1:0 = 10 is stored in `wr5_byte` only when bits 6 and 2 are both 0. Otherwise it is dropped.
- R8: Load (0xCF) copies `addr_a` to `cnt_a` and `addr_b` to `cnt_b`, and zeroes `byte_cnt`, `match_flg` and `endb_flg`.
- R9: Interrupt enable (0xAB) and disable (0xAF) set and clear `int_en`. Force ready (0xB3) copies `wr5_byte` bit 3 to `rdy_lvl`, which resets to 1. Reset (0xC3) zeroes `xfer_kind` and `int_en`. Read-mask-follows (0xBB) queues `rd_mask`. Disable (0x83) leaves `dma_en` at 0.
- R10: Continue (0xD3) zeroes `byte_cnt`, `match_flg` and `endb_flg` and sets `dma_en`. If a pause is pending, the pending flag is cleared and each counter moves by its port configuration bits 5:4: 00 decrements, 01 increments, 1x holds.
- R11: While `pend_cnt` is nonzero, a written byte goes to the oldest pending target and `pend_cnt` drops by one, plus any targets that byte appends. With no write, `pend_cnt` holds. The ring never holds more than `QDEPTH` entries, and `wr_ready` is 1 after reset.
- R12: `evt_byte` increments `byte_cnt`. `evt_match` and `evt_end` set `match_flg` and `endb_flg`. `evt_pause` sets the pending-pause flag, which the enable and reset commands clear. After reset all registers are 0 except `rdy_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Control byte offered |
| wr_ready | output | 1 | Always 1 after reset; byte taken when valid |
| wr_data | input | 8 | Control byte |
| evt_byte | input | 1 | Engine moved one byte |
| evt_match | input | 1 | Engine saw a match |
| evt_end | input | 1 | Engine reached end of block |
| evt_pause | input | 1 | Engine paused mid-transfer |
| xfer_kind | output | 2 | Transfer kind from group-0 byte |
| xfer_mode | output | 2 | Transfer mode from group-4 byte |
| addr_a | output | AW | Port A start address |
| addr_b | output | AW | Port B start address |
| blk_len | output | AW | Block length |
| cnt_a | output | AW | Port A working counter |
| cnt_b | output | AW | Port B working counter |
| byte_cnt | output | AW | Bytes moved since load/continue |
| cfg_a | output | 8 | Port A configuration byte |
| cfg_b | output | 8 | Port B configuration byte |
| mask_byte | output | 8 | Match mask |
| match_byte | output | 8 | Match value |
| ictl_byte | output | 8 | Interrupt-control byte |
| pulse_byte | output | 8 | Pulse count |
| vec_byte | output | 8 | Interrupt vector |
| wr5_byte | output | 8 | Group-5 byte |
| rd_mask | output | 8 | Read-back mask |
| dma_en | output | 1 | Transfer enable |
| int_en | output | 1 | Interrupt enable |
| rdy_lvl | output | 1 | Forced ready level |
| match_flg | output | 1 | Match flag |
| endb_flg | output | 1 | End-of-block flag |
| pend_cnt | output | CW | Parameter bytes still expected |

## Verification
The hardest state to reach is an interrupt-control byte that extends the ring while earlier targets are still being consumed. The stimulus gets there with a group-4 byte that queues both port B address bytes and the control byte. It then writes a control byte with both append bits set, so the ring grows at its tail partway through the sequence and the pulse and vector bytes must land after it. The second hard case is a pause that must be pending when continue arrives. The bench pulses the pause event between commands, crosses each counter direction (increment, decrement, hold), and shows that a second continue, or an enable in between, no longer moves the counters.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [3:0] {
    T_AL, T_AH, T_LL, T_LH, T_SKIP, T_MASK, T_MATCH,
    T_BL, T_BH, T_ICTL, T_PULSE, T_VEC, T_RMASK
  } tgt_e;

  typedef enum logic [2:0] {
    G_W0, G_CFGA, G_CFGB, G_W3, G_W4, G_W5, G_CMD, G_NONE
  } grp_e;

  typedef enum logic [3:0] {
    C_NOP, C_DIS, C_EN, C_IEN, C_IDIS, C_FRDY, C_RMF, C_RST, C_LOAD, C_CONT
  } cmd_e;

  localparam int MAXPUSH = 4;
endpackage

// File: rtl/dma_base_decode.sv
module dma_base_decode
  import dma_seq_pkg::*;
(
  input  logic [7:0] d,
  output grp_e       grp,
  output cmd_e       cmd,
  output logic [2:0] n,
  output tgt_e       t [MAXPUSH]
);
  always_comb begin
    if (!d[7]) begin
      if (d[1:0] != 2'b00) grp = G_W0;
      else                 grp = d[2] ? G_CFGA : G_CFGB;
    end else begin
      case (d[1:0])
        2'b00:   grp = G_W3;
        2'b01:   grp = (d[6:5] == 2'b11) ? G_NONE : G_W4;
        2'b10:   grp = (!d[6] && !d[2]) ? G_W5 : G_NONE;
        default: grp = G_CMD;
      endcase
    end
  end

  always_comb begin
    case (d[6:2])
      5'h00:   cmd = C_DIS;
      5'h01:   cmd = C_EN;
      5'h0A:   cmd = C_IEN;
      5'h0B:   cmd = C_IDIS;
      5'h0C:   cmd = C_FRDY;
      5'h0E:   cmd = C_RMF;
      5'h10:   cmd = C_RST;
      5'h13:   cmd = C_LOAD;
      5'h14:   cmd = C_CONT;
      default: cmd = C_NOP;
    endcase
  end

  always_comb begin
    n = '0;
    for (int i = 0; i < MAXPUSH; i++) t[i] = T_SKIP;
    case (grp)
      G_W0: begin
        for (int k = 0; k < 4; k++) begin
          if (d[3+k]) begin
            t[n[1:0]] = tgt_e'(4'(k));
            n = n + 3'd1;
          end
        end
      end
      G_CFGA, G_CFGB: begin
        if (d[6]) begin t[0] = T_SKIP; n = 3'd1; end
      end
      G_W3: begin
        if (d[3]) begin t[n[1:0]] = T_MASK;  n = n + 3'd1; end
        if (d[4]) begin t[n[1:0]] = T_MATCH; n = n + 3'd1; end
      end
      G_W4: begin
        if (d[2]) begin t[n[1:0]] = T_BL;   n = n + 3'd1; end
        if (d[3]) begin t[n[1:0]] = T_BH;   n = n + 3'd1; end
        if (d[4]) begin t[n[1:0]] = T_ICTL; n = n + 3'd1; end
      end
      G_CMD: begin
        if (cmd == C_RMF) begin t[0] = T_RMASK; n = 3'd1; end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dma_tgt_queue.sv
module dma_tgt_queue
  import dma_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pop,
  input  logic [2:0]    push_n,
  input  tgt_e          push_t [MAXPUSH],
  output tgt_e          head,
  output logic [CW-1:0] cnt
);
  tgt_e          slot [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] base;

  assign head = slot[rd_ptr];
  assign base = clr ? '0 : rd_ptr + PW'(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      cnt    <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= T_SKIP;
    end else begin
      for (int i = 0; i < MAXPUSH; i++) begin
        if (3'(i) < push_n) slot[base + PW'(i)] <= push_t[i];
      end
      rd_ptr <= clr ? '0 : rd_ptr + PW'(pop);
      cnt    <= cnt - CW'(pop) + CW'(push_n);
    end
  end
endmodule

// File: rtl/dma_ctr_step.sv
module dma_ctr_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [1:0]    dir,
  output logic [AW-1:0] nxt
);
  always_comb begin
    case (dir)
      2'b00:   nxt = cur - AW'(1);
      2'b01:   nxt = cur + AW'(1);
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int QDEPTH = 8,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  input  logic          evt_byte,
  input  logic          evt_match,
  input  logic          evt_end,
  input  logic          evt_pause,
  output logic [1:0]    xfer_kind,
  output logic [1:0]    xfer_mode,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic [AW-1:0] blk_len,
  output logic [AW-1:0] cnt_a,
  output logic [AW-1:0] cnt_b,
  output logic [AW-1:0] byte_cnt,
  output logic [7:0]    cfg_a,
  output logic [7:0]    cfg_b,
  output logic [7:0]    mask_byte,
  output logic [7:0]    match_byte,
  output logic [7:0]    ictl_byte,
  output logic [7:0]    pulse_byte,
  output logic [7:0]    vec_byte,
  output logic [7:0]    wr5_byte,
  output logic [7:0]    rd_mask,
  output logic          dma_en,
  output logic          int_en,
  output logic          rdy_lvl,
  output logic          match_flg,
  output logic          endb_flg,
  output logic [CW-1:0] pend_cnt
);
  grp_e          grp;
  cmd_e          cmd;
  logic [2:0]    dec_n;
  tgt_e          dec_t [MAXPUSH];
  tgt_e          ext_t [MAXPUSH];
  tgt_e          q_t   [MAXPUSH];
  tgt_e          head;
  logic [2:0]    q_n;
  logic          base_wr, param_wr, ictl_wr;
  logic [AW-1:0] addr_q [2];
  logic [AW-1:0] cnt_q  [2];
  logic [AW-1:0] step_q [2];
  logic [7:0]    cfg_q  [2];
  logic          pend_inc;
  logic          rdy_q;

  assign base_wr  = wr_valid && (pend_cnt == '0);
  assign param_wr = wr_valid && (pend_cnt != '0);
  assign ictl_wr  = param_wr && (head == T_ICTL);

  dma_base_decode u_dec (.d(wr_data), .grp(grp), .cmd(cmd), .n(dec_n), .t(dec_t));

  always_comb begin
    for (int i = 0; i < MAXPUSH; i++) ext_t[i] = T_SKIP;
    ext_t[0] = wr_data[3] ? T_PULSE : T_VEC;
    ext_t[1] = T_VEC;
    for (int i = 0; i < MAXPUSH; i++) q_t[i] = base_wr ? dec_t[i] : ext_t[i];
    if (base_wr)      q_n = dec_n;
    else if (ictl_wr) q_n = 3'(wr_data[3]) + 3'(wr_data[4]);
    else              q_n = '0;
  end

  dma_tgt_queue #(.DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .clr(base_wr), .pop(param_wr),
    .push_n(q_n), .push_t(q_t), .head(head), .cnt(pend_cnt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_port
    dma_ctr_step #(.AW(AW)) u_step (.cur(cnt_q[g]), .dir(cfg_q[g][5:4]), .nxt(step_q[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_kind <= '0; xfer_mode <= '0; blk_len <= '0; byte_cnt <= '0;
      for (int g = 0; g < 2; g++) begin
        addr_q[g] <= '0; cnt_q[g] <= '0; cfg_q[g] <= '0;
      end
      mask_byte <= '0; match_byte <= '0; ictl_byte <= '0; pulse_byte <= '0;
      vec_byte <= '0; wr5_byte <= '0; rd_mask <= '0;
      dma_en <= 1'b0; int_en <= 1'b0; rdy_q <= 1'b1;
      match_flg <= 1'b0; endb_flg <= 1'b0; pend_inc <= 1'b0;
    end else begin
      if (evt_byte)  byte_cnt  <= byte_cnt + AW'(1);
      if (evt_match) match_flg <= 1'b1;
      if (evt_end)   endb_flg  <= 1'b1;
      if (evt_pause) pend_inc  <= 1'b1;
      if (wr_valid)  dma_en    <= 1'b0;

      if (param_wr) begin
        case (head)
          T_AL:    addr_q[0][7:0]  <= wr_data;
          T_AH:    addr_q[0][15:8] <= wr_data;
          T_LL:    blk_len[7:0]    <= wr_data;
          T_LH:    blk_len[15:8]   <= wr_data;
          T_BL:    addr_q[1][7:0]  <= wr_data;
          T_BH:    addr_q[1][15:8] <= wr_data;
          T_MASK:  mask_byte       <= wr_data;
          T_MATCH: match_byte      <= wr_data;
          T_ICTL:  ictl_byte       <= wr_data;
          T_PULSE: pulse_byte      <= wr_data;
          T_VEC:   vec_byte        <= wr_data;
          T_RMASK: rd_mask         <= wr_data;
          default: ;
        endcase
      end

      if (base_wr) begin
        case (grp)
          G_W0:   xfer_kind <= wr_data[1:0];
          G_CFGA: cfg_q[0]  <= wr_data;
          G_CFGB: cfg_q[1]  <= wr_data;
          G_W3: begin
            int_en <= wr_data[5];
            dma_en <= wr_data[6];
          end
          G_W4:   xfer_mode <= wr_data[6:5];
          G_W5:   wr5_byte  <= wr_data;
          G_CMD: begin
            case (cmd)
              C_EN:   begin pend_inc <= 1'b0; dma_en <= 1'b1; end
              C_IEN:  int_en <= 1'b1;
              C_IDIS: int_en <= 1'b0;
              C_FRDY: rdy_q  <= wr5_byte[3];
              C_RST:  begin xfer_kind <= '0; int_en <= 1'b0; pend_inc <= 1'b0; end
              C_LOAD: begin
                cnt_q[0] <= addr_q[0]; cnt_q[1] <= addr_q[1];
                byte_cnt <= '0; match_flg <= 1'b0; endb_flg <= 1'b0;
              end
              C_CONT: begin
                if (pend_inc) begin
                  cnt_q[0] <= step_q[0]; cnt_q[1] <= step_q[1];
                  pend_inc <= 1'b0;
                end
                byte_cnt <= '0; match_flg <= 1'b0; endb_flg <= 1'b0;
                dma_en   <= 1'b1;
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_ready = 1'b1;
  assign rdy_lvl  = rdy_q;
  assign addr_a   = addr_q[0];
  assign addr_b   = addr_q[1];
  assign cnt_a    = cnt_q[0];
  assign cnt_b    = cnt_q[1];
  assign cfg_a    = cfg_q[0];
  assign cfg_b    = cfg_q[1];
endmodule

// File: rtl/dma_cmd_seq_chk.sv
module dma_cmd_seq_chk #(
  parameter int AW = 16,
  parameter int QDEPTH = 8,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [7:0]    wr_data,
  input logic          dma_en,
  input logic          int_en,
  input logic [7:0]    wr5_byte,
  input logic [AW-1:0] addr_a,
  input logic [AW-1:0] addr_b,
  input logic [AW-1:0] cnt_a,
  input logic [AW-1:0] cnt_b,
  input logic [AW-1:0] byte_cnt,
  input logic [CW-1:0] pend_cnt
);
  logic base;
  assign base = wr_valid && (pend_cnt == '0);

  AST_EN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_en) |-> $past(wr_valid)); // R1
  AST_GRP3_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (base && wr_data[7] && wr_data[1:0] == 2'b00)
      |=> (int_en == $past(wr_data[5])) && (dma_en == $past(wr_data[6]))); // R4
  AST_GRP5_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (base && wr_data[7:6] == 2'b11 && wr_data[1:0] == 2'b10) |=> $stable(wr5_byte)); // R7
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (base && wr_data == 8'hCF)
      |=> (cnt_a == $past(addr_a)) && (cnt_b == $past(addr_b)) && (byte_cnt == '0)); // R8
  AST_CONT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (base && wr_data == 8'hD3) |=> dma_en && (byte_cnt == '0)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pend_cnt) <= QDEPTH); // R11
  AST_IDLE_HOLDS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(pend_cnt)); // R11
  AST_PARAM_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && pend_cnt != '0) |=> 32'(pend_cnt) <= 32'($past(pend_cnt)) + 1); // R6
endmodule

bind dma_cmd_seq dma_cmd_seq_chk #(.AW(AW), .QDEPTH(QDEPTH)) u_chk (.*);

// File: tb/tb_dma_cmd_seq.sv
module tb_dma_cmd_seq;
  localparam int AW = 16;
  localparam int QDEPTH = 8;
  localparam int CW = $clog2(QDEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0, wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic evt_byte = 1'b0, evt_match = 1'b0, evt_end = 1'b0, evt_pause = 1'b0;
  logic wr_ready, dma_en, int_en, rdy_lvl, match_flg, endb_flg;
  logic [1:0] xfer_kind, xfer_mode;
  logic [AW-1:0] addr_a, addr_b, blk_len, cnt_a, cnt_b, byte_cnt;
  logic [7:0] cfg_a, cfg_b, mask_byte, match_byte, ictl_byte, pulse_byte, vec_byte, wr5_byte, rd_mask;
  logic [CW-1:0] pend_cnt;

  always #5 clk = ~clk;

  dma_cmd_seq #(.AW(AW), .QDEPTH(QDEPTH)) dut (.*);

  typedef enum int {F_EN, F_IE, F_PEND, F_RDY, F_KIND, F_MODE, F_AA, F_AB, F_LEN, F_CA, F_CB,
                    F_BC, F_CFGA, F_CFGB, F_MASK, F_MATCHB, F_ICTL, F_PULSE, F_VEC, F_WR5,
                    F_RMASK, F_MF, F_EF, F_WRDY} fld_e;
  typedef struct { fld_e f; logic [31:0] v; string req; } item_t;
  item_t sbq [$];
  int nchk = 0, nfail = 0;
  bit done = 0;

  function automatic logic [31:0] peek(fld_e f);
    case (f)
      F_EN: return 32'(dma_en);        F_IE: return 32'(int_en);
      F_PEND: return 32'(pend_cnt);    F_RDY: return 32'(rdy_lvl);
      F_KIND: return 32'(xfer_kind);   F_MODE: return 32'(xfer_mode);
      F_AA: return 32'(addr_a);        F_AB: return 32'(addr_b);
      F_LEN: return 32'(blk_len);      F_CA: return 32'(cnt_a);
      F_CB: return 32'(cnt_b);         F_BC: return 32'(byte_cnt);
      F_CFGA: return 32'(cfg_a);       F_CFGB: return 32'(cfg_b);
      F_MASK: return 32'(mask_byte);   F_MATCHB: return 32'(match_byte);
      F_ICTL: return 32'(ictl_byte);   F_PULSE: return 32'(pulse_byte);
      F_VEC: return 32'(vec_byte);     F_WR5: return 32'(wr5_byte);
      F_RMASK: return 32'(rd_mask);    F_MF: return 32'(match_flg);
      F_EF: return 32'(endb_flg);      default: return 32'(wr_ready);
    endcase
  endfunction

  task automatic exp(fld_e f, logic [31:0] v, string req);
    item_t it;
    it.f = f; it.v = v; it.req = req;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      nchk++;
      if (peek(it.f) !== it.v) begin
        nfail++;
        $display("FAIL %s %s: actual %0h expected %0h", it.req, it.f.name(), peek(it.f), it.v);
      end
    end
  end

  task automatic wr(logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_data = b;
    @(posedge clk); #1; wr_valid = 1'b0;
  endtask

  task automatic ev(logic bt, logic mt, logic en, logic ps);
    @(negedge clk); evt_byte = bt; evt_match = mt; evt_end = en; evt_pause = ps;
    @(posedge clk); #1; evt_byte = 0; evt_match = 0; evt_end = 0; evt_pause = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    exp(F_EN, 0, "R12"); exp(F_IE, 0, "R12"); exp(F_PEND, 0, "R12");
    exp(F_RDY, 1, "R12"); exp(F_WRDY, 1, "R11"); exp(F_AA, 0, "R12");

    // R2 full group-0 sequence
    wr(8'h79); exp(F_PEND, 4, "R2"); exp(F_KIND, 1, "R2");
    wr(8'h34); wr(8'h12); wr(8'h00); wr(8'h01);
    exp(F_AA, 16'h1234, "R2"); exp(F_LEN, 16'h0100, "R2"); exp(F_PEND, 0, "R11");
    // R2 sparse flags
    wr(8'h29); exp(F_PEND, 2, "R2");
    wr(8'hAA); wr(8'h55);
    exp(F_AA, 16'h12AA, "R2"); exp(F_LEN, 16'h0155, "R2");

    // R3 config bytes, timing byte ignored
    wr(8'h54); exp(F_CFGA, 8'h54, "R3"); exp(F_PEND, 1, "R3");
    wr(8'hFF); exp(F_PEND, 0, "R3"); exp(F_CFGA, 8'h54, "R3"); exp(F_AA, 16'h12AA, "R3");
    exp(F_LEN, 16'h0155, "R3");
    wr(8'h00); exp(F_CFGB, 8'h00, "R3"); exp(F_PEND, 0, "R3");

    // R5/R6 group 4 with mid-sequence extension
    wr(8'h9D); exp(F_PEND, 3, "R5"); exp(F_MODE, 0, "R5");
    wr(8'h00); wr(8'h20); exp(F_AB, 16'h2000, "R5"); exp(F_PEND, 1, "R11");
    wr(8'h18); exp(F_ICTL, 8'h18, "R6"); exp(F_PEND, 2, "R6");
    wr(8'h05); exp(F_PULSE, 8'h05, "R6"); exp(F_PEND, 1, "R6");
    wr(8'h42); exp(F_VEC, 8'h42, "R6"); exp(F_PEND, 0, "R6");
    wr(8'hA1); exp(F_MODE, 1, "R5"); exp(F_PEND, 0, "R5");
    wr(8'hE1); exp(F_MODE, 1, "R5"); exp(F_PEND, 0, "R5");

    // R7 group 5 filter
    wr(8'h8A); exp(F_WR5, 8'h8A, "R7");
    wr(8'hCA); exp(F_WR5, 8'h8A, "R7");
    wr(8'h8E); exp(F_WR5, 8'h8A, "R7");

    // R4 group 3
    wr(8'h98); exp(F_PEND, 2, "R4"); exp(F_IE, 0, "R4");
    wr(8'h0F); wr(8'h33); exp(F_MASK, 8'h0F, "R4"); exp(F_MATCHB, 8'h33, "R4");
    wr(8'hE0); exp(F_IE, 1, "R4"); exp(F_EN, 1, "R4"); exp(F_PEND, 0, "R4");
    wr(8'h82); exp(F_EN, 0, "R1"); exp(F_WR5, 8'h82, "R7");

    // R9 commands
    wr(8'hAF); exp(F_IE, 0, "R9");
    wr(8'hAB); exp(F_IE, 1, "R9");
    wr(8'hB3); exp(F_RDY, 0, "R9");
    wr(8'h8A); wr(8'hB3); exp(F_RDY, 1, "R9");
    wr(8'hBB); exp(F_PEND, 1, "R9");
    wr(8'h7F); exp(F_RMASK, 8'h7F, "R9"); exp(F_PEND, 0, "R9");
    wr(8'h87); exp(F_EN, 1, "R1");
    wr(8'h83); exp(F_EN, 0, "R9");
    wr(8'hC3); exp(F_KIND, 0, "R9"); exp(F_IE, 0, "R9");

    // R12 events then R8 load
    ev(1, 1, 0, 0); ev(1, 0, 1, 0); ev(1, 0, 0, 0);
    exp(F_BC, 3, "R12"); exp(F_MF, 1, "R12"); exp(F_EF, 1, "R12");
    wr(8'hCF);
    exp(F_CA, 16'h12AA, "R8"); exp(F_CB, 16'h2000, "R8"); exp(F_BC, 0, "R8");
    exp(F_MF, 0, "R8"); exp(F_EF, 0, "R8"); exp(F_EN, 0, "R1");

    // R10 continue
    ev(1, 1, 0, 0);
    wr(8'hD3); exp(F_CA, 16'h12AA, "R10"); exp(F_CB, 16'h2000, "R10");
    exp(F_EN, 1, "R10"); exp(F_BC, 0, "R10"); exp(F_MF, 0, "R10");
    ev(1, 0, 0, 1);
    wr(8'hD3); exp(F_CA, 16'h12AB, "R10"); exp(F_CB, 16'h1FFF, "R10"); exp(F_BC, 0, "R10");
    wr(8'hD3); exp(F_CA, 16'h12AB, "R10"); exp(F_CB, 16'h1FFF, "R10");
    ev(0, 0, 0, 1); wr(8'h87); wr(8'hD3);
    exp(F_CA, 16'h12AB, "R12"); exp(F_CB, 16'h1FFF, "R12");
    ev(0, 0, 0, 1); wr(8'hC3); wr(8'hD3);
    exp(F_CA, 16'h12AB, "R12"); exp(F_CB, 16'h1FFF, "R12");
    wr(8'h24); exp(F_CFGA, 8'h24, "R3");
    ev(0, 0, 0, 1); wr(8'hD3);
    exp(F_CA, 16'h12AB, "R10"); exp(F_CB, 16'h1FFE, "R10");

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule